// File: doc/BRIEF.md
# Reloadable Serial Baud Tick Generator

This block makes the oversampling tick for an asynchronous serial port. The receiver and transmitter both consume the tick. Its rate is sixteen times the line baud rate. The input clock first passes through a small fixed prescaler. The prescaler divides by 2 or by 3, chosen by a select input. A down-counter follows it and restarts from a programmable reload value.

The reload value holds the integer divisor halved, minus one. The halving comes from the divide-by-2 prescaler that normally comes first. With select `s` the prescaler ratio P is 2 (s=0) or 3 (s=1). With reload value R, one tick appears every P×(R+1) input clocks.

A run input starts and stops the generator. While it is low, the prescaler and counter are held at their starting point and no tick appears. Software clears run, writes the reload value, then sets run again. A reload write made while run is high is dropped. A fractional-divider enable input exists but has no effect: the fractional path is not built.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is applied, and in the cycles after reset until the first write, `tick` is 0 and `reload_value` is 0.
- R2: With `pre_sel`=0 (divide-by-2) and reload R, `tick` is high once every 2×(R+1) clocks while `run_en` is high. The first tick comes 2×(R+1) clocks after run is sampled high.
- R3: With `pre_sel`=1 (divide-by-3) and reload R, `tick` is high once every 3×(R+1) clocks. Its phase follows the same rule as R2.
- R4: `tick` is a single-cycle pulse: it is never high in two consecutive cycles.
- R5: When `run_en` is sampled low, `tick` is 0 on the next cycle. The next time run is set, the full period elapses before the first tick, whatever partial count had built up.
- R6: A reload write (`reload_wr`=1) sampled while `run_en` is high is ignored. `reload_value` and the tick period stay unchanged, even when the write lands on a terminal-count cycle.
- R7: A reload write sampled while `run_en` is low updates `reload_value` on the next cycle. A run started on the very next cycle uses the new value.
- R8: `frac_en` has no effect on the tick timing or on the reload value.
- R9: The boundary reload values work: R=0 gives a tick every P clocks, and R=2^W−1 gives a tick every P×2^W clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Run control: 1 counts, 0 holds the generator and accepts reload writes |
| pre_sel | input | 1 | Prescaler select: 0 divides by 2, 1 divides by 3 |
| frac_en | input | 1 | Fractional-divider enable, ignored |
| reload_wr | input | 1 | Reload write strobe |
| reload_wdata | input | RELOAD_W | Reload value to write |
| reload_value | output | RELOAD_W | Current reload register contents |
| tick | output | 1 | Oversampling tick, one clock wide |

## Verification
Two collisions matter here. The first is a reload write on the very edge where the counter hits terminal count and reloads. The bench pokes the reload strobe on every cycle of a run, so some strokes land on tick edges. The write must be dropped and the next period must still use the old value. The second is clearing run on the same edge that would produce a tick. The bench does this by running for exactly one period, then stopping and restarting. The behavioural reference, which counts run cycles modulo the period, judges tick and reload value on every clock.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  typedef enum logic {
    PRE_DIV2 = 1'b0,
    PRE_DIV3 = 1'b1
  } pre_sel_e;

endpackage

// File: rtl/bgen_rst_sync.sv
module bgen_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/bgen_reload_reg.sv
module bgen_reload_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] reload_q_o,
  output logic [W-1:0] reload_nxt_o
);

  logic         wr_accept;
  logic [W-1:0] reload_q;

  always_comb begin
    wr_accept    = wr_i && !run_i;
    reload_nxt_o = wr_accept ? wdata_i : reload_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (wr_accept) reload_q <= wdata_i;
  end

  assign reload_q_o = reload_q;

  // R6
  write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && run_i) |=> $stable(reload_q));

  // R7
  write_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !run_i) |=> (reload_q == $past(wdata_i)));

endmodule

// File: rtl/bgen_prescaler.sv
module bgen_prescaler
  import baud_gen_pkg::*;
#(
  parameter int DIV_LO = 2,
  parameter int DIV_HI = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_i,
  input  pre_sel_e sel_i,
  output logic     ce_o
);

  localparam int CW = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;

  logic [CW-1:0] pcnt_q, pcnt_d, limit;
  logic          at_limit;

  always_comb begin
    limit    = (sel_i == PRE_DIV3) ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
    at_limit = (pcnt_q >= limit);
    ce_o     = run_i && at_limit;
    if (!run_i)       pcnt_d = '0;
    else if (at_limit) pcnt_d = '0;
    else              pcnt_d = pcnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R4
  ce_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_o |=> !ce_o);

  // R3
  pcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= CW'(DIV_HI - 1));

  // R5
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (pcnt_q == '0));

endmodule

// File: rtl/bgen_divcnt.sv
module bgen_divcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         ce_i,
  input  logic [W-1:0] reload_q_i,
  input  logic [W-1:0] reload_nxt_i,
  output logic         tick_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         tick_q, tick_d, terminal;

  always_comb begin
    terminal = (cnt_q == '0);
    tick_d   = run_i && ce_i && terminal;
    if (!run_i)        cnt_d = reload_nxt_i;
    else if (!ce_i)    cnt_d = cnt_q;
    else if (terminal) cnt_d = reload_q_i;
    else               cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R4
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

  // R5
  halt_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !tick_q);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= reload_q_i));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_gen_pkg::*;
#(
  parameter int RELOAD_W    = 16,
  parameter int DIV_LO      = 2,
  parameter int DIV_HI      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic                pre_sel,
  input  logic                frac_en,
  input  logic                reload_wr,
  input  logic [RELOAD_W-1:0] reload_wdata,
  output logic [RELOAD_W-1:0] reload_value,
  output logic                tick
);

  logic                rst_l;
  logic                ce;
  logic [RELOAD_W-1:0] reload_q, reload_nxt;

  bgen_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_l)
  );

  bgen_reload_reg #(.W(RELOAD_W)) u_reload (
    .clk          (clk),
    .rst_n        (rst_l),
    .run_i        (run_en),
    .wr_i         (reload_wr),
    .wdata_i      (reload_wdata),
    .reload_q_o   (reload_q),
    .reload_nxt_o (reload_nxt)
  );

  bgen_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
    .clk   (clk),
    .rst_n (rst_l),
    .run_i (run_en),
    .sel_i (pre_sel_e'(pre_sel)),
    .ce_o  (ce)
  );

  bgen_divcnt #(.W(RELOAD_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_l),
    .run_i        (run_en),
    .ce_i         (ce),
    .reload_q_i   (reload_q),
    .reload_nxt_i (reload_nxt),
    .tick_o       (tick)
  );

  assign reload_value = reload_q;

  // R8
  frac_no_write_chk: assert property (@(posedge clk) disable iff (!rst_l)
    (run_en && reload_wr && frac_en) |=> $stable(reload_value));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_l |-> (!tick && reload_value == '0));

endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         run_en, pre_sel, frac_en, reload_wr;
  logic [W-1:0] reload_wdata;
  logic [W-1:0] reload_value;
  logic         tick;

  int    checks = 0;
  int    fails  = 0;
  int    obs_ticks = 0;
  bit    prev_tick = 1'b0;
  string cur_req = "R1";

  // behavioural reference
  int       rel = 0;
  int       m_n = 0;
  int       m_rld = 0;
  bit       m_tick = 1'b0;

  always #5 clk = ~clk;

  baud_tick_gen #(.RELOAD_W(W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .pre_sel      (pre_sel),
    .frac_en      (frac_en),
    .reload_wr    (reload_wr),
    .reload_wdata (reload_wdata),
    .reload_value (reload_value),
    .tick         (tick)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0; m_n = 0; m_rld = 0; m_tick = 1'b0;
    end else begin
      if (rel >= 2) begin
        if (!run_en) begin
          m_n = 0; m_tick = 1'b0;
          if (reload_wr) m_rld = int'(reload_wdata);
        end else begin
          m_n++;
          m_tick = (m_n % ((pre_sel ? 3 : 2) * (m_rld + 1))) == 0;
        end
      end
      if (rel < 2) rel++;
    end
    #2;
    checks++;
    if (tick !== m_tick) begin
      fails++;
      $display("FAIL %s: tick actual=%0b expected=%0b at %0t", cur_req, tick, m_tick, $time);
    end
    checks++;
    if (int'(reload_value) !== m_rld) begin
      fails++;
      $display("FAIL %s: reload_value actual=%0d expected=%0d", cur_req, reload_value, m_rld);
    end
    checks++;
    if (tick && prev_tick) begin  // R4 single-cycle pulse
      fails++;
      $display("FAIL R4: tick actual=11 expected=10 in consecutive cycles");
    end
    prev_tick = tick;
    if (tick) obs_ticks++;
  end

  task automatic check_int(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_seg(string req, bit sel, bit frac, logic [W-1:0] rld,
                         int ncyc, bit poke);
    int per;
    per = (sel ? 3 : 2) * (int'(rld) + 1);
    @(negedge clk);
    cur_req = req;
    run_en = 1'b0; reload_wr = 1'b1; reload_wdata = rld;
    pre_sel = sel; frac_en = frac;
    @(negedge clk);
    reload_wr = 1'b0;
    check_int("R7", "reload_value after stopped write", int'(reload_value), int'(rld));
    obs_ticks = 0;
    run_en = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      if (poke) begin
        reload_wr = 1'b1;
        reload_wdata = ~rld ^ i[W-1:0];
      end
      @(negedge clk);
    end
    run_en = 1'b0; reload_wr = 1'b0;
    @(negedge clk);
    check_int(req, "tick count", obs_ticks, ncyc / per);
    check_int(req, "reload_value kept", int'(reload_value), int'(rld));
  endtask

  initial begin
    rst_n = 1'b1;
    run_en = 1'b0; pre_sel = 1'b0; frac_en = 1'b0;
    reload_wr = 1'b0; reload_wdata = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_int("R1", "tick in reset", int'(tick), 0);
    check_int("R1", "reload_value in reset", int'(reload_value), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_int("R1", "tick after reset", int'(tick), 0);
    check_int("R1", "reload_value after reset", int'(reload_value), 0);

    run_seg("R2", 1'b0, 1'b0, 8'd4,   100, 1'b0);
    run_seg("R2", 1'b0, 1'b0, 8'd9,   123, 1'b0);
    run_seg("R3", 1'b1, 1'b0, 8'd4,    90, 1'b0);
    run_seg("R3", 1'b1, 1'b0, 8'd6,    70, 1'b0);
    run_seg("R9", 1'b0, 1'b0, 8'd0,    40, 1'b0);
    run_seg("R9", 1'b1, 1'b0, 8'd0,    30, 1'b0);
    run_seg("R9", 1'b1, 1'b0, 8'd255, 1540, 1'b0);
    run_seg("R8", 1'b0, 1'b1, 8'd4,   100, 1'b0);
    run_seg("R8", 1'b1, 1'b1, 8'd2,    45, 1'b1);
    run_seg("R6", 1'b0, 1'b0, 8'd3,    80, 1'b1);
    run_seg("R6", 1'b0, 1'b0, 8'd0,    20, 1'b1);
    // R5: partial count discarded, stop on tick edge, restart
    run_seg("R5", 1'b0, 1'b0, 8'd4,     7, 1'b0);
    run_seg("R5", 1'b0, 1'b0, 8'd4,    10, 1'b0);
    run_seg("R5", 1'b0, 1'b0, 8'd4,    19, 1'b0);
    run_seg("R7", 1'b1, 1'b0, 8'd1,    60, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: cycles actual=100000 expected=fewer");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule